// File: doc/BRIEF.md
# Protection Tuple Inserter

This block writes an end-to-end protection tuple into the metadata area that travels with each logical block, for the case where the storage controller generates protection on the host's behalf. For every block it is handed the metadata bytes, the guard value that an upstream engine has already computed, the application tag and the request's starting reference tag. It returns the metadata with the tuple placed at the right offset. It does no data movement and no CRC work itself.

Two tuple formats are supported. The short form is 8 bytes: a 16-bit guard, a 16-bit application tag and a 32-bit reference tag. The long form is 16 bytes: a 64-bit guard, a 16-bit application tag and a 48-bit reference tag. The tuple sits either at the start or at the end of the metadata. The reference tag either advances block by block or holds still, depending on the protection type.

A write-zeroes mode builds tuples for blocks of zeros without a guard input. In that mode a request that also asks for any protection check is refused.

Top module: `pi_inserter`

## Requirements
- R1: Each block with `in_valid` high produces `out_valid` high exactly one clock later. A cycle without `in_valid` produces `out_valid` low one clock later.
- R2: Short format (`in_fmt64`=0), tuple bytes 0..7: guard[15:0] big-endian, application tag big-endian, reference tag[31:0] big-endian. Long format (`in_fmt64`=1), tuple bytes 0..15: guard[63:0] big-endian, application tag big-endian, reference tag[47:0] as six bytes with the most significant byte first. Metadata byte i occupies `in_meta`/`out_meta` bits [8i+7:8i].
- R3: With `in_first`=1 the tuple starts at metadata byte 0. With `in_first`=0 it starts at byte META_BYTES minus the tuple length (8 or 16).
- R4: Outside write-zeroes mode, metadata bytes outside the tuple are copied unchanged from `in_meta`.
- R5: A block with `in_start`=1 uses `in_ref` as its reference tag. For type codes 1 and 2 (code 0 acts as 1), each accepted block's successor uses the previous tag plus one, modulo 2^48. The short format writes only the low 32 bits.
- R6: For type code 3 the reference tag does not change from block to block.
- R7: In write-zeroes mode (`in_wz`=1), bytes outside the tuple are zero and `in_guard` is ignored. The guard field is 0 in the short format and 64'h6482D367EB22B64E in the long format.
- R8: A write-zeroes block with any bit of `in_chk` set is refused. One clock later `out_reject` and `out_dnr` are high and `out_meta` equals the `in_meta` of that block. A refused block does not advance the reference tag.
- R9: After reset `out_valid`, `out_reject`, `out_dnr` are low and `out_meta` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One block presented this cycle |
| in_start | input | 1 | First block of a request; load `in_ref` |
| in_fmt64 | input | 1 | 1 = 16-byte long tuple, 0 = 8-byte short tuple |
| in_ptype | input | 2 | Protection type code (1, 2, 3) |
| in_first | input | 1 | 1 = tuple at start of metadata, 0 = at end |
| in_wz | input | 1 | Write-zeroes mode |
| in_chk | input | 3 | Check-enable bits of the request |
| in_app | input | 16 | Application tag |
| in_ref | input | 48 | Starting reference tag |
| in_guard | input | 64 | Precomputed guard for this block |
| in_meta | input | 8*META_BYTES | Incoming metadata bytes |
| out_valid | output | 1 | Result valid |
| out_meta | output | 8*META_BYTES | Metadata with tuple inserted |
| out_reject | output | 1 | Invalid protection information |
| out_dnr | output | 1 | Do-not-retry qualifier of the refusal |

## Verification
Every result of the block comes from one register stage. The metadata, `out_valid`, `out_reject` and `out_dnr` for a block therefore appear at the first rising edge after the block is presented. The bench drives each block on a falling edge and reads all outputs at the next falling edge, half a period after that rising edge. It then reads one more falling edge to confirm that `out_valid` has dropped. Reference-tag sequencing is checked over a series of blocks, because each block's tag depends on the register that the previous accepted block updated.

// File: rtl/pi_pkg.sv
package pi_pkg;
   localparam int unsigned TUPLE_SHORT = 8;
   localparam int unsigned TUPLE_LONG  = 16;
   localparam int unsigned REF_W       = 48;
   localparam int unsigned GUARD_W     = 64;
   localparam int unsigned APP_W       = 16;
   localparam int unsigned CHK_W       = 3;
   localparam logic [1:0]  PTYPE_HOLD  = 2'd3;
   localparam logic [GUARD_W-1:0] ZERO_BLOCK_GUARD64 = 64'h6482_d367_eb22_b64e;
endpackage

// File: rtl/pi_ref_track.sv
module pi_ref_track
   import pi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             start,
   input  logic             hold,
   input  logic [REF_W-1:0] start_ref,
   output logic [REF_W-1:0] cur_tag
);
   logic [REF_W-1:0] ref_q;

   assign cur_tag = start ? start_ref : ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
      end else if (advance) begin
         ref_q <= hold ? cur_tag : cur_tag + REF_W'(1);
      end
   end
endmodule

// File: rtl/pi_tuple_build.sv
module pi_tuple_build
   import pi_pkg::*;
(
   input  logic                    fmt64,
   input  logic                    wz,
   input  logic [GUARD_W-1:0]      guard,
   input  logic [APP_W-1:0]        app,
   input  logic [REF_W-1:0]        ref_tag,
   output logic [TUPLE_LONG*8-1:0] tup
);
   logic [15:0]        g_short;
   logic [GUARD_W-1:0] g_long;

   always_comb begin
      g_short = wz ? 16'h0000 : guard[15:0];
      g_long  = wz ? ZERO_BLOCK_GUARD64 : guard;
      tup     = '0;
      if (!fmt64) begin
         tup[0*8 +: 8] = g_short[15:8];
         tup[1*8 +: 8] = g_short[7:0];
         tup[2*8 +: 8] = app[15:8];
         tup[3*8 +: 8] = app[7:0];
         for (int k = 0; k < 4; k++) begin
            tup[(4+k)*8 +: 8] = ref_tag[31-8*k -: 8];
         end
      end else begin
         for (int k = 0; k < 8; k++) begin
            tup[k*8 +: 8] = g_long[63-8*k -: 8];
         end
         tup[8*8 +: 8] = app[15:8];
         tup[9*8 +: 8] = app[7:0];
         for (int k = 0; k < 6; k++) begin
            tup[(10+k)*8 +: 8] = ref_tag[47-8*k -: 8];
         end
      end
   end
endmodule

// File: rtl/pi_place.sv
module pi_place
   import pi_pkg::*;
#(
   parameter int unsigned META_BYTES = 24
) (
   input  logic                    first,
   input  logic                    fmt64,
   input  logic                    wz,
   input  logic [TUPLE_LONG*8-1:0] tup,
   input  logic [META_BYTES*8-1:0] meta_in,
   output logic [META_BYTES*8-1:0] meta_out
);
   localparam int unsigned OFF_W = $clog2(META_BYTES + 1);
   localparam logic [OFF_W-1:0] END_SHORT = OFF_W'(META_BYTES - TUPLE_SHORT);
   localparam logic [OFF_W-1:0] END_LONG  = OFF_W'(META_BYTES - TUPLE_LONG);

   logic [OFF_W-1:0] off;
   logic [OFF_W-1:0] tlen;

   assign tlen = fmt64 ? OFF_W'(TUPLE_LONG) : OFF_W'(TUPLE_SHORT);
   assign off  = first ? '0 : (fmt64 ? END_LONG : END_SHORT);

   for (genvar gi = 0; gi < META_BYTES; gi++) begin : g_byte
      localparam logic [OFF_W-1:0] IDX = OFF_W'(gi);
      logic [OFF_W-1:0] rel;
      logic             hit;
      always_comb begin
         rel = IDX - off;
         hit = (IDX >= off) && (rel < tlen);
         if (hit) begin
            meta_out[gi*8 +: 8] = tup[{rel[3:0], 3'b000} +: 8];
         end else begin
            meta_out[gi*8 +: 8] = wz ? 8'h00 : meta_in[gi*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/pi_inserter.sv
module pi_inserter
   import pi_pkg::*;
#(
   parameter int unsigned META_BYTES = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_start,
   input  logic                    in_fmt64,
   input  logic [1:0]              in_ptype,
   input  logic                    in_first,
   input  logic                    in_wz,
   input  logic [2:0]              in_chk,
   input  logic [15:0]             in_app,
   input  logic [47:0]             in_ref,
   input  logic [63:0]             in_guard,
   input  logic [META_BYTES*8-1:0] in_meta,
   output logic                    out_valid,
   output logic [META_BYTES*8-1:0] out_meta,
   output logic                    out_reject,
   output logic                    out_dnr
);
   if (META_BYTES < TUPLE_LONG) begin : g_bad_meta
      $error("pi_inserter: META_BYTES must hold a 16-byte tuple");
   end

   logic                    refuse;
   logic [REF_W-1:0]        tag;
   logic [TUPLE_LONG*8-1:0] tup;
   logic [META_BYTES*8-1:0] placed;

   assign refuse = in_wz && (in_chk != '0);

   pi_ref_track u_ref (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (in_valid && !refuse),
      .start    (in_start),
      .hold     (in_ptype == PTYPE_HOLD),
      .start_ref(in_ref),
      .cur_tag  (tag)
   );

   pi_tuple_build u_tup (
      .fmt64  (in_fmt64),
      .wz     (in_wz),
      .guard  (in_guard),
      .app    (in_app),
      .ref_tag(tag),
      .tup    (tup)
   );

   pi_place #(.META_BYTES(META_BYTES)) u_place (
      .first   (in_first),
      .fmt64   (in_fmt64),
      .wz      (in_wz),
      .tup     (tup),
      .meta_in (in_meta),
      .meta_out(placed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_reject <= 1'b0;
         out_dnr    <= 1'b0;
         out_meta   <= '0;
      end else begin
         out_valid  <= in_valid;
         out_reject <= in_valid && refuse;
         out_dnr    <= in_valid && refuse;
         if (in_valid) begin
            out_meta <= refuse ? in_meta : placed;
         end
      end
   end
endmodule

// File: rtl/pi_inserter_chk.sv
module pi_inserter_chk #(
   parameter int unsigned META_BYTES = 24
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_fmt64,
   input logic                    in_first,
   input logic                    in_wz,
   input logic [2:0]              in_chk,
   input logic                    out_valid,
   input logic [META_BYTES*8-1:0] out_meta,
   input logic                    out_reject,
   input logic                    out_dnr
);
   // R1: one-cycle valid latency
   a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R8: refusal of write-zeroes with checks
   a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_wz && (in_chk != 3'b000)) |=> (out_reject && out_dnr));
   a_r8_no_false_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_wz && (in_chk != 3'b000)) |=> (!out_reject && !out_dnr));
   // R7: fixed guard values in write-zeroes mode, tuple at start
   a_r7_wz_short_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_wz && (in_chk == 3'b000) && !in_fmt64 && in_first)
      |=> (out_meta[15:0] == 16'h0000));
   a_r7_wz_long_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_wz && (in_chk == 3'b000) && in_fmt64 && in_first)
      |=> (out_meta[63:0] == 64'h4eb6_22eb_67d3_8264));
endmodule

bind pi_inserter pi_inserter_chk #(.META_BYTES(META_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_fmt64  (in_fmt64),
   .in_first  (in_first),
   .in_wz     (in_wz),
   .in_chk    (in_chk),
   .out_valid (out_valid),
   .out_meta  (out_meta),
   .out_reject(out_reject),
   .out_dnr   (out_dnr)
);

// File: tb/sim_pi_inserter.sv
`timescale 1ns/1ps
module sim_pi_inserter;
   localparam int MB = 24;

   typedef struct packed {
      logic        fmt64;
      logic [1:0]  ptype;
      logic        first;
      logic        wz;
      logic        start;
      logic [2:0]  chk;
      logic [15:0] app;
      logic [47:0] sref;
      logic [63:0] guard;
      logic [7:0]  seed;
      logic [47:0] exp_ref;
      logic        exp_rej;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TAB [NV] = '{
      '{1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 3'd0, 16'hBEEF, 48'h0000_1234_5678, 64'h0000_0000_0000_A5C3, 8'h10, 48'h0000_1234_5678, 1'b0},
      '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 16'hBEEF, 48'h0, 64'h0000_0000_0000_1357, 8'h20, 48'h0000_1234_5679, 1'b0},
      '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 3'd0, 16'hBEEF, 48'h0, 64'h0000_0000_0000_2468, 8'h30, 48'h0000_1234_567A, 1'b0},
      '{1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 3'd0, 16'h1111, 48'hABCD_EF01_2345, 64'h0123_4567_89AB_CDEF, 8'h40, 48'hABCD_EF01_2345, 1'b0},
      '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 16'h2222, 48'h0, 64'hFEDC_BA98_7654_3210, 8'h50, 48'hABCD_EF01_2346, 1'b0},
      '{1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 3'd0, 16'h3333, 48'h0000_0000_0099, 64'h0000_0000_0000_0F0F, 8'h60, 48'h0000_0000_0099, 1'b0},
      '{1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 3'd0, 16'h3333, 48'h0, 64'h0000_0000_0000_F0F0, 8'h70, 48'h0000_0000_0099, 1'b0},
      '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 3'd0, 16'h4444, 48'h0000_0000_0500, 64'hFFFF_FFFF_FFFF_FFFF, 8'h80, 48'h0000_0000_0500, 1'b0},
      '{1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 3'd2, 16'h4444, 48'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h90, 48'h0, 1'b1},
      '{1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 3'd0, 16'h4444, 48'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hA0, 48'h0000_0000_0501, 1'b0},
      '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 3'd0, 16'h5555, 48'h0000_0000_0007, 64'h1234_1234_1234_1234, 8'hB0, 48'h0000_0000_0007, 1'b0},
      '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 3'd0, 16'h6666, 48'h0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 8'hC0, 48'h0000_FFFF_FFFF, 1'b0},
      '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 3'd0, 16'h6666, 48'h0, 64'h0000_0000_0000_0002, 8'hD0, 48'h0001_0000_0000, 1'b0}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0, in_start = 1'b0, in_fmt64 = 1'b0;
   logic [1:0]      in_ptype = '0;
   logic            in_first = 1'b0, in_wz = 1'b0;
   logic [2:0]      in_chk = '0;
   logic [15:0]     in_app = '0;
   logic [47:0]     in_ref = '0;
   logic [63:0]     in_guard = '0;
   logic [MB*8-1:0] in_meta = '0;
   logic            out_valid, out_reject, out_dnr;
   logic [MB*8-1:0] out_meta;

   int errs = 0;
   int total = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pi_inserter #(.META_BYTES(MB)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
      .in_fmt64(in_fmt64), .in_ptype(in_ptype), .in_first(in_first),
      .in_wz(in_wz), .in_chk(in_chk), .in_app(in_app), .in_ref(in_ref),
      .in_guard(in_guard), .in_meta(in_meta), .out_valid(out_valid),
      .out_meta(out_meta), .out_reject(out_reject), .out_dnr(out_dnr)
   );

   task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
      total++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [MB*8-1:0] pattern(logic [7:0] seed);
      logic [MB*8-1:0] m;
      for (int i = 0; i < MB; i++) m[i*8 +: 8] = seed + 8'(i * 7);
      return m;
   endfunction

   function automatic logic [MB*8-1:0] model(vec_t v);
      logic [7:0]      t [16];
      logic [MB*8-1:0] src, res;
      logic [63:0]     g;
      int              tl, off;
      src = pattern(v.seed);
      if (v.exp_rej) return src;
      tl  = v.fmt64 ? 16 : 8;
      off = v.first ? 0 : MB - tl;
      if (v.fmt64) begin
         g = v.wz ? 64'h6482_d367_eb22_b64e : v.guard;
         for (int k = 0; k < 8; k++) t[k] = g[63-8*k -: 8];
         t[8] = v.app[15:8]; t[9] = v.app[7:0];
         for (int k = 0; k < 6; k++) t[10+k] = v.exp_ref[47-8*k -: 8];
      end else begin
         g = v.wz ? 64'h0 : v.guard;
         t[0] = g[15:8]; t[1] = g[7:0];
         t[2] = v.app[15:8]; t[3] = v.app[7:0];
         for (int k = 0; k < 4; k++) t[4+k] = v.exp_ref[31-8*k -: 8];
         for (int k = 8; k < 16; k++) t[k] = 8'h00;
      end
      for (int i = 0; i < MB; i++) begin
         if (i >= off && i < off + tl) res[i*8 +: 8] = t[i-off];
         else res[i*8 +: 8] = v.wz ? 8'h00 : src[i*8 +: 8];
      end
      return res;
   endfunction

   function automatic string req_of(vec_t v);
      if (v.exp_rej) return "R8";
      if (v.wz) return "R7";
      if (v.ptype == 2'd3) return "R6";
      if (v.start) return "R3/R4";
      return "R2/R5";
   endfunction

   initial begin
      #(8 * 200000);
      if (!done) begin
         errs++; total++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errs, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 out_valid", 256'(out_valid), 256'(0));
      check("R9 out_reject", 256'(out_reject), 256'(0));
      check("R9 out_dnr", 256'(out_dnr), 256'(0));
      check("R9 out_meta", 256'(out_meta), 256'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", 256'(out_valid), 256'(0));

      for (int n = 0; n < NV; n++) begin
         vec_t v;
         v = TAB[n];
         in_valid = 1'b1;   in_start = v.start; in_fmt64 = v.fmt64;
         in_ptype = v.ptype; in_first = v.first; in_wz = v.wz;
         in_chk   = v.chk;   in_app = v.app;     in_ref = v.sref;
         in_guard = v.guard; in_meta = pattern(v.seed);
         @(negedge clk);
         in_valid = 1'b0;
         check({"R1 valid ", req_of(v)}, 256'(out_valid), 256'(1));
         check({"R8 reject flag ", req_of(v)}, 256'(out_reject), 256'(v.exp_rej));
         check({"R8 dnr flag ", req_of(v)}, 256'(out_dnr), 256'(v.exp_rej));
         check({"meta ", req_of(v)}, 256'(out_meta), 256'(model(v)));
         @(negedge clk);
         check("R1 valid drops", 256'(out_valid), 256'(0));
      end

      // R1: two back-to-back blocks, type 1 advancing across adjacent cycles
      in_valid = 1'b1; in_start = 1'b1; in_fmt64 = 1'b0; in_ptype = 2'd0;
      in_first = 1'b1; in_wz = 1'b0; in_chk = 3'd5; in_app = 16'h0A0B;
      in_ref = 48'h0000_0000_0010; in_guard = 64'h0; in_meta = '0;
      @(negedge clk);
      in_start = 1'b0;
      check("R5 back-to-back first tag", 256'(out_meta[63:32]), 256'(32'h1000_0000));
      @(negedge clk);
      in_valid = 1'b0;
      check("R5 back-to-back second tag", 256'(out_meta[63:32]), 256'(32'h1100_0000));
      check("R1 back-to-back valid", 256'(out_valid), 256'(1));
      @(negedge clk);
      check("R1 back-to-back end", 256'(out_valid), 256'(0));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end
endmodule